// File: doc/BRIEF.md
# Dual-channel serial PCM codec port

This block connects a processor register bus to two external 8-bit telephone codecs. The codecs share one serial clock, one transmit line and one receive line. Each codec has its own frame-sync output. The block derives the serial clock from the system clock and counts serial-clock periods to set the frame rate. Within each frame it runs the channel 0 transfer and then the channel 1 transfer. After the last enabled channel finishes, it gives a one-cycle active-low interrupt.

Software drives the block through three bus addresses. Address 0 is channel 0 data, address 1 is channel 1 data, and address 2 is the control word. Each channel keeps two words:

- a staging word, whose low byte goes out on the serial line and is overwritten bit by bit with the incoming sample;
- a hold word, which the bus reads.

A bus write to a data address copies the staging word into the hold word and loads the written value as the new staging word. The usual order is: take the interrupt, write the next outgoing sample, then read back the sample just received. No companding is done: the low byte is sent as it is, and received bytes come back zero-extended.

Top module: `pcm_codec_port`

## Requirements
- R1: While reset is held, sclk, txd, fsync0 and fsync1 are low, irq_n is high, and bus_rdata reads zero at all four addresses.
- R2: The control word at address 2 reads back exactly as written. Its fields are:
  - bits 3:0: prescaler field PS;
  - bits 11:4: frame ratio field FR;
  - bit 12: channel 0 enable;
  - bit 13: channel 1 enable;
  - bits 15:14: stored with no effect.
- R3: While at least one channel is enabled, sclk has a period of 2*(16-PS) system cycles with equal high and low times. Its first rising edge comes on the first clock edge after the enabling write. While both channels are disabled, sclk stays low.
- R4: A frame lasts 256-FR serial-clock periods, so frame-sync pulses start once every 2*(16-PS)*(256-FR) system cycles. FR must not exceed 240.
- R5: Serial-clock periods 0 to 7 of a frame form the channel 0 window, and periods 8 to 15 form the channel 1 window. An enabled channel's frame sync rises on the sclk rising edge that opens its window and falls on the sclk rising edge that ends it. fsync0 and fsync1 are never high together.
- R6: In an enabled window, txd carries the low byte of that channel's staging word, most significant bit first. Each bit changes on a rising sclk edge. Outside any enabled window txd is low.
- R7: rxd is sampled on each falling sclk edge of an enabled window. The samples are stored most significant bit first into the low byte of that channel's staging word, and bits 15:8 of that word are cleared on the first sample.
- R8: A bus write to address 0 (channel 0) or address 1 (channel 1) moves the old staging word into the hold word and loads the written word as the staging word. A read of that address returns the hold word, and address 3 reads zero. A bus write takes priority over a serial sample in the same cycle.
- R9: irq_n goes low for exactly one system cycle, right after the final falling sclk edge of the last enabled channel's window, once per frame.
- R10: A disabled channel never raises its frame sync and never changes its staging word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Bus address: 0 channel 0, 1 channel 1, 2 control |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data for bus_addr |
| sclk | output | 1 | Serial clock to both codecs |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data, synchronous to clk |
| fsync0 | output | 1 | Channel 0 frame sync, active high |
| fsync1 | output | 1 | Channel 1 frame sync, active high |
| irq_n | output | 1 | Transfer-complete pulse, active low |

## Verification
The assertions check rules that must hold on every cycle:
- the two frame syncs never overlap;
- the interrupt pulse is one cycle wide and coincides with a falling serial clock;
- txd changes only with a rising serial clock or when the port stops;
- the serial clock is held low while idle;
- a frame sync only starts for an enabled channel.

Some behaviour depends on long runs of the prescaler and frame counter or on data, and only the bench's scenarios can show it:
- the exact serial-clock period for a given prescaler field;
- the frame period for a given ratio field;
- the bit order on txd and rxd;
- the hold and staging exchange on bus writes;
- a disabled channel's staging word surviving a run.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int P_DATA_W   = 16;
  localparam int P_SAMPLE_W = 8;
  localparam int P_PSC_W    = 4;
  localparam int P_RATIO_W  = 8;
  localparam int P_NUM_CH   = 2;
  localparam int P_ADDR_W   = 2;

  typedef enum logic [P_ADDR_W-1:0] {
    ADDR_CH0  = 2'd0,
    ADDR_CH1  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_NONE = 2'd3
  } port_addr_e;

  typedef struct packed {
    logic [1:0]            spare;
    logic [P_NUM_CH-1:0]   en;
    logic [P_RATIO_W-1:0]  ratio;
    logic [P_PSC_W-1:0]    psc;
  } ctrl_t;
endpackage

// File: rtl/pcm_sclk_gen.sv
module pcm_sclk_gen #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  logic [PSC_W-1:0] pre_q, pre_d;
  logic             sclk_q, sclk_d;
  logic             wrap;

  // the prescaler wraps after reaching all ones; each wrap is one half period
  assign wrap = run && (pre_q == '1);
  assign rise = wrap && !sclk_q;
  assign fall = wrap && sclk_q;
  assign sclk = sclk_q;

  always_comb begin
    pre_d  = pre_q;
    sclk_d = sclk_q;
    if (!run) begin
      pre_d  = '1;
      sclk_d = 1'b0;
    end else if (wrap) begin
      pre_d  = psc;
      sclk_d = ~sclk_q;
    end else begin
      pre_d  = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '1;
      sclk_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      sclk_q <= sclk_d;
    end
  end
endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq #(
  parameter int SAMPLE_W = 8,
  parameter int RATIO_W  = 8,
  parameter int NUM_CH   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             run,
  input  logic                             rise,
  input  logic                             fall,
  input  logic [RATIO_W-1:0]               ratio,
  input  logic [NUM_CH-1:0]                en,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]  tx_bytes,
  output logic [NUM_CH-1:0]                fs,
  output logic                             txd,
  output logic                             irq_n,
  output logic [NUM_CH-1:0]                rx_we,
  output logic [$clog2(SAMPLE_W)-1:0]      rx_idx,
  output logic                             rx_first
);
  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam int CH_W  = RATIO_W - IDX_W;

  logic [RATIO_W-1:0] fcnt_q, fcnt_d;
  logic [NUM_CH-1:0]  fs_q, fs_d;
  logic               txd_q, txd_d;
  logic               irq_q, irq_d;

  logic [CH_W-1:0]    slot_ch;
  logic [IDX_W-1:0]   idx;
  logic [NUM_CH-1:0]  in_win;
  logic [CH_W-1:0]    last_ch;
  logic               last_hit;
  logic               tx_bit;

  assign slot_ch = fcnt_q[RATIO_W-1:IDX_W];
  assign idx     = fcnt_q[IDX_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_win
    assign in_win[c] = en[c] && (slot_ch == CH_W'(c));
    assign rx_we[c]  = fall && in_win[c];
  end

  assign rx_idx   = idx;
  assign rx_first = (idx == '0);

  // highest enabled channel closes the frame
  always_comb begin
    last_ch = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (en[c]) last_ch = CH_W'(c);
    end
  end
  assign last_hit = (|en) && (slot_ch == last_ch) && (idx == '1);

  always_comb begin
    tx_bit = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (in_win[c]) tx_bit = tx_bytes[c][~idx];
    end
  end

  always_comb begin
    fcnt_d = fcnt_q;
    fs_d   = fs_q;
    txd_d  = txd_q;
    irq_d  = 1'b1;
    if (!run) begin
      fcnt_d = '0;
      fs_d   = '0;
      txd_d  = 1'b0;
    end else begin
      if (rise) begin
        fs_d  = in_win;
        txd_d = tx_bit;
      end
      if (fall) begin
        fcnt_d = (fcnt_q == ~ratio) ? '0 : fcnt_q + 1'b1;
        irq_d  = ~last_hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      fs_q   <= '0;
      txd_q  <= 1'b0;
      irq_q  <= 1'b1;
    end else begin
      fcnt_q <= fcnt_d;
      fs_q   <= fs_d;
      txd_q  <= txd_d;
      irq_q  <= irq_d;
    end
  end

  assign fs    = fs_q;
  assign txd   = txd_q;
  assign irq_n = irq_q;
endmodule

// File: rtl/pcm_chan_buf.sv
module pcm_chan_buf #(
  parameter int DATA_W   = 16,
  parameter int SAMPLE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_we,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        rx_we,
  input  logic [$clog2(SAMPLE_W)-1:0] rx_idx,
  input  logic                        rx_first,
  input  logic                        rx_bit,
  output logic [DATA_W-1:0]           stage_o,
  output logic [DATA_W-1:0]           hold_o
);
  logic [DATA_W-1:0]   stage_q, stage_d;
  logic [DATA_W-1:0]   hold_q, hold_d;
  logic [SAMPLE_W-1:0] low;

  always_comb begin
    stage_d = stage_q;
    hold_d  = hold_q;
    low     = stage_q[SAMPLE_W-1:0];
    if (bus_we) begin
      hold_d  = stage_q;
      stage_d = bus_wdata;
    end else if (rx_we) begin
      low[~rx_idx] = rx_bit;
      stage_d[SAMPLE_W-1:0] = low;
      if (rx_first) stage_d[DATA_W-1:SAMPLE_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      stage_q <= stage_d;
      hold_q  <= hold_d;
    end
  end

  assign stage_o = stage_q;
  assign hold_o  = hold_q;
endmodule

// File: rtl/pcm_codec_port.sv
module pcm_codec_port
  import pcm_port_pkg::*;
#(
  parameter int DATA_W   = P_DATA_W,
  parameter int SAMPLE_W = P_SAMPLE_W,
  parameter int ADDR_W   = P_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              txd,
  input  logic              rxd,
  output logic              fsync0,
  output logic              fsync1,
  output logic              irq_n
);
  localparam int NUM_CH = P_NUM_CH;
  localparam int IDX_W  = $clog2(SAMPLE_W);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctrl_t ctrl_q, ctrl_d;
  logic  run;

  always_comb begin
    ctrl_d = ctrl_q;
    if (bus_we && (bus_addr == ADDR_CTRL)) ctrl_d = ctrl_t'(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  assign run = |ctrl_q.en;

  logic rise, fall;

  pcm_sclk_gen #(.PSC_W(P_PSC_W)) i_sclk (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (run),
    .psc   (ctrl_q.psc),
    .sclk  (sclk),
    .rise  (rise),
    .fall  (fall)
  );

  logic [NUM_CH-1:0][SAMPLE_W-1:0] tx_bytes;
  logic [NUM_CH-1:0]               fs;
  logic [NUM_CH-1:0]               rx_we;
  logic [IDX_W-1:0]                rx_idx;
  logic                            rx_first;
  logic [DATA_W-1:0]               stage [NUM_CH];
  logic [DATA_W-1:0]               hold  [NUM_CH];

  pcm_frame_seq #(
    .SAMPLE_W (SAMPLE_W),
    .RATIO_W  (P_RATIO_W),
    .NUM_CH   (NUM_CH)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .rise     (rise),
    .fall     (fall),
    .ratio    (ctrl_q.ratio),
    .en       (ctrl_q.en),
    .tx_bytes (tx_bytes),
    .fs       (fs),
    .txd      (txd),
    .irq_n    (irq_n),
    .rx_we    (rx_we),
    .rx_idx   (rx_idx),
    .rx_first (rx_first)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_we;
    assign ch_we = bus_we && (bus_addr == ADDR_W'(c));

    pcm_chan_buf #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W)) i_buf (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .bus_we    (ch_we),
      .bus_wdata (bus_wdata),
      .rx_we     (rx_we[c]),
      .rx_idx    (rx_idx),
      .rx_first  (rx_first),
      .rx_bit    (rxd),
      .stage_o   (stage[c]),
      .hold_o    (hold[c])
    );
    assign tx_bytes[c] = stage[c][SAMPLE_W-1:0];
  end

  always_comb begin
    case (bus_addr)
      ADDR_CH0:  bus_rdata = hold[0];
      ADDR_CH1:  bus_rdata = hold[1];
      ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
      default:   bus_rdata = '0;
    endcase
  end

  assign fsync0 = fs[0];
  assign fsync1 = fs[1];
endmodule

// File: rtl/pcm_codec_port_chk.sv
module pcm_codec_port_chk
  import pcm_port_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  sclk,
  input logic  txd,
  input logic  fsync0,
  input logic  fsync1,
  input logic  irq_n,
  input logic  run,
  input ctrl_t ctrl_q
);
  AST_FS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fsync0 && fsync1)); // R5

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |=> irq_n); // R9

  AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $fell(sclk)); // R9

  AST_TXD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> ($rose(sclk) || !$past(run))); // R6

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk); // R3

  AST_FS0_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync0) |-> $past(ctrl_q.en[0])); // R10

  AST_FS1_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync1) |-> $past(ctrl_q.en[1])); // R10
endmodule

bind pcm_codec_port pcm_codec_port_chk i_chk (.*);

// File: tb/test_pcm_codec_port.sv
`timescale 1ns/1ps
module test_pcm_codec_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        sclk, txd, rxd, fsync0, fsync1, irq_n;

  always #2.5 clk = ~clk;

  pcm_codec_port i_pcm_codec_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .txd(txd),
    .rxd(rxd), .fsync0(fsync0), .fsync1(fsync1), .irq_n(irq_n)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  int          m_t;
  logic [15:0] m_stage [2];
  logic [15:0] m_hold  [2];
  logic [15:0] m_ctrl;
  logic        m_sclk, m_fs0, m_fs1, m_txd, m_irq;

  logic        nx_we = 0;
  logic [1:0]  nx_addr = 0;
  logic [15:0] nx_wd = 0;
  logic [15:0] lfsr = 16'hACE1;

  int  exp_period = 0;
  int  last_rise = -1;
  logic prev_fs = 0;
  int  fs0_hi = 0, sclk_hi = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit run;
    int n, p, ph, slot, c, idx, last;
    logic [15:0] old0, old1;
    run  = m_ctrl[12] | m_ctrl[13];
    n    = 16 - int'(m_ctrl[3:0]);
    p    = 256 - int'(m_ctrl[11:4]);
    old0 = m_stage[0];
    old1 = m_stage[1];
    m_irq = 1'b1;
    if (!run) begin
      m_t = -1; m_sclk = 0; m_fs0 = 0; m_fs1 = 0; m_txd = 0;
    end else begin
      m_t  = (m_t < 0) ? 0 : m_t + 1;
      ph   = m_t % (2 * n);
      slot = (m_t / (2 * n)) % p;
      c    = slot / 8;
      idx  = slot % 8;
      if (ph == 0) begin
        m_sclk = 1;
        m_fs0  = m_ctrl[12] && slot < 8;
        m_fs1  = m_ctrl[13] && slot >= 8 && slot < 16;
        m_txd  = (c < 2 && m_ctrl[12+c]) ? m_stage[c][7-idx] : 1'b0;
      end else if (ph == n) begin
        m_sclk = 0;
        if (c < 2 && m_ctrl[12+c]) begin
          m_stage[c][7-idx] = rxd;
          if (idx == 0) m_stage[c][15:8] = 8'h00;
        end
        last = m_ctrl[13] ? 15 : 7;
        if (slot == last) m_irq = 1'b0;
      end
    end
    if (bus_we) begin
      case (bus_addr)
        2'd0: begin m_hold[0] = old0; m_stage[0] = bus_wdata; end
        2'd1: begin m_hold[1] = old1; m_stage[1] = bus_wdata; end
        2'd2: m_ctrl = bus_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    logic [15:0] exp_rd;
    case (bus_addr)
      2'd0: exp_rd = m_hold[0];
      2'd1: exp_rd = m_hold[1];
      2'd2: exp_rd = m_ctrl;
      default: exp_rd = 16'h0;
    endcase
    check(sclk == m_sclk, "R3", "sclk", 16'(sclk), 16'(m_sclk));
    check(fsync0 == m_fs0, "R5", "fsync0", 16'(fsync0), 16'(m_fs0));
    check(fsync1 == m_fs1, "R5", "fsync1", 16'(fsync1), 16'(m_fs1));
    check(txd == m_txd, "R6", "txd", 16'(txd), 16'(m_txd));
    check(irq_n == m_irq, "R9", "irq_n", 16'(irq_n), 16'(m_irq));
    check(bus_rdata == exp_rd, "R8", "rdata", bus_rdata, exp_rd);
    if ((fsync0 | fsync1) && !prev_fs) begin
      if (last_rise >= 0)
        check(cyc - last_rise == exp_period, "R4", "frame period",
              16'(cyc - last_rise), 16'(exp_period));
      last_rise = cyc;
    end
    prev_fs = fsync0 | fsync1;
    if (fsync0) fs0_hi++;
    if (sclk) sclk_hi++;
  endtask

  task automatic apply_and_step();
    bus_we    = nx_we;
    bus_addr  = nx_addr;
    bus_wdata = nx_wd;
    rxd       = lfsr[0];
    lfsr      = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    model_step();
  endtask

  task automatic cycle();
    @(negedge clk);
    compare();
    cyc++;
    apply_and_step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    nx_we = 1; nx_addr = a; nx_wd = d;
    if (a == 2'd2) last_rise = -1;
    cycle();
    nx_we = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    nx_addr = a;
    cycle();
    #1 v = bus_rdata;
  endtask

  initial begin
    logic [15:0] v;
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; rxd = 0;
    m_t = -1; m_stage[0] = 0; m_stage[1] = 0; m_hold[0] = 0; m_hold[1] = 0;
    m_ctrl = 0; m_sclk = 0; m_fs0 = 0; m_fs1 = 0; m_txd = 0; m_irq = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclk == 0 && txd == 0, "R1", "sclk/txd in reset", {14'h0, sclk, txd}, 16'h0);
    check(fsync0 == 0 && fsync1 == 0, "R1", "fsync in reset", {14'h0, fsync1, fsync0}, 16'h0);
    check(irq_n == 1, "R1", "irq_n in reset", 16'(irq_n), 16'h1);
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a);
      #1 check(bus_rdata == 0, "R1", "rdata in reset", bus_rdata, 16'h0);
    end
    @(negedge clk);
    rst_n = 1;
    apply_and_step();
    idle(4);

    // R2 control readback, reserved bits kept, no enables
    bus_write(2'd2, 16'hC0D5);
    peek(2'd2, v);
    check(v == 16'hC0D5, "R2", "control readback", v, 16'hC0D5);

    // R8 staging / hold exchange
    bus_write(2'd0, 16'h12A5);
    peek(2'd0, v);
    check(v == 16'h0000, "R8", "first hold ch0", v, 16'h0000);
    bus_write(2'd0, 16'h00C3);
    peek(2'd0, v);
    check(v == 16'h12A5, "R8", "second hold ch0", v, 16'h12A5);
    bus_write(2'd1, 16'h345A);
    peek(3, v);
    check(v == 16'h0000, "R8", "address 3 reads zero", v, 16'h0000);

    // both channels, PS=13, FR=240
    exp_period = 2 * 3 * 16;
    bus_write(2'd2, 16'h3F0D);
    idle(300);
    bus_write(2'd2, 16'h0000);
    idle(3);
    bus_write(2'd0, 16'h5555);
    peek(2'd0, v);
    check(v[15:8] == 8'h00, "R7", "received word zero-extended", v, {8'h00, v[7:0]});
    check(v == m_hold[0], "R7", "received ch0 byte", v, m_hold[0]);
    bus_write(2'd1, 16'h6666);
    peek(2'd1, v);
    check(v == m_hold[1] && v[15:8] == 0, "R7", "received ch1 byte", v, m_hold[1]);

    // channel 1 only, PS=15, FR=200
    fs0_hi = 0;
    exp_period = 2 * 1 * 56;
    bus_write(2'd2, 16'h2C8F);
    idle(300);
    bus_write(2'd2, 16'h0000);
    check(fs0_hi == 0, "R10", "fsync0 high while disabled", 16'(fs0_hi), 16'h0);
    idle(3);
    bus_write(2'd0, 16'h7777);
    peek(2'd0, v);
    check(v == 16'h5555, "R10", "disabled ch0 staging kept", v, 16'h5555);

    // channel 0 only, PS=0, FR=240
    exp_period = 2 * 16 * 16;
    bus_write(2'd2, 16'h1F00);
    idle(1100);
    bus_write(2'd2, 16'h0000);
    idle(3);

    // both disabled: idle serial clock
    sclk_hi = 0;
    idle(100);
    check(sclk_hi == 0, "R3", "sclk idle while disabled", 16'(sclk_hi), 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule